// File: doc/BRIEF.md
# Gated-Clock Serial Frame Receiver

This block receives 16-bit words from an external device over a three-wire serial link: a bit clock, a data line and a sync line. The receiver always drives the bit clock, even though the data comes from the far end. The external device changes data after each rising clock edge. The receiver captures the data line on each falling edge and shifts it in MSB first. Each complete word is presented on a parallel output for one cycle, with a valid strobe and a track index. The bit rate is set outside the block: a one-cycle enable advances the bit clock by one half period.

The link has two modes, selected by a static input.

- **Continuous mode.** The clock runs freely and the receiver drives sync. A frame is 128 bit clocks long and holds eight 16-bit slots. Sync is high during the first slot. Only the first `trackCount` slots of each frame are delivered. The index of the slot is attached to each word.
- **Handshaked mode.** Sync becomes an input from the external device. While that input is high, the receiver issues 16-clock bursts, one word per burst. A fixed idle gap follows each burst before sync is looked at again. When the device drops sync before its current word ends, no further burst starts.

Top module: `gated_serial_rx`

## Requirements
- R1: While reset is asserted, the bit clock output, the sync output and the word valid output are all low.
- R2: In continuous mode the bit clock inverts on every enable pulse and never stops. Between two frame starts there are exactly 128 rising edges.
- R3: In continuous mode the sync output enable is 1. Sync is high for the first 16 rising edges of each frame and low for the remaining 112. In handshaked mode the sync output enable is 0.
- R4: The data line is sampled at each falling clock edge. A word is assembled from 16 consecutive samples, and the first sample becomes bit 15.
- R5: In continuous mode, the word of slot t (t = 0..7, clock periods 16t to 16t+15 of the frame) appears on the word output. It appears one cycle after the clock edge that produces its last falling edge, with the track index equal to t.
- R6: In continuous mode, slots with index greater than or equal to `trackCount` (0..8) produce no valid. Exactly `trackCount` words are delivered per frame.
- R7: In handshaked mode the bit clock stays low and no word is delivered while the sync input is low between bursts. Raising sync again resumes transfers.
- R8: In handshaked mode, once started, a burst is exactly 16 clock periods long even if sync drops during it. Its word is delivered with track index 0.
- R9: In handshaked mode, while sync stays high, the first rising edge of the next burst comes exactly five enable pulses after the falling edge that ended the previous burst. This gives at least two idle clock periods.
- R10: The word valid output is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | Half-bit-period enable from an external divider |
| modeHs | input | 1 | 1 = handshaked mode, 0 = continuous mode |
| trackCount | input | 4 | Slots delivered per continuous frame (0..8) |
| serClk | output | 1 | Bit clock driven toward the external device |
| serData | input | 1 | Serial data from the external device |
| syncIn | input | 1 | Transfer request from the device (handshaked mode) |
| syncOut | output | 1 | Frame sync toward the device (continuous mode) |
| syncOe | output | 1 | Drive enable for syncOut |
| wordOut | output | 16 | Received word |
| wordValid | output | 1 | One-cycle strobe for wordOut |
| trackOut | output | 3 | Slot index of wordOut |

## Verification
The bit clock and the continuous sync change at the rising system-clock edge on which an enable pulse is present. Words are due one system clock after the edge that produced their final falling bit-clock edge. The handshaked gap ends exactly five enable periods after the end of a burst. The bench samples every output at the falling system-clock edge and models the far-end device from the bit-clock transitions it observes there. Each expectation is therefore tied to the observed clock edge rather than to an absolute cycle count. Gap lengths are counted in system clocks and compared with five times the enable period.

// File: rtl/gsr_pkg.sv
package gsr_pkg;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_BURST = 2'd1,
    HS_GAP   = 2'd2
  } hsState_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic sampleEn;  // falling bit-clock step: shift serData in
    logic wordEnd;   // this falling step carries the last bit of a word
  } dpStrobe_t;

endpackage

// File: rtl/gsr_ctrl.sv
module gsr_ctrl
  import gsr_pkg::*;
#(
  parameter int WORD_BITS  = 16,
  parameter int FRAME_BITS = 128,
  parameter int GAP_STEPS  = 4,
  localparam int CNT_W  = $clog2(FRAME_BITS),
  localparam int WCNT_W = $clog2(WORD_BITS),
  localparam int TRK_W  = CNT_W - WCNT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic             modeHs,
  input  logic             syncIn,
  output logic             serClk,
  output logic             syncOut,
  output logic             syncOe,
  output dpStrobe_t        strobe,
  output logic [TRK_W-1:0] trackIdx
);

  localparam int GAP_W = $clog2(GAP_STEPS);
  localparam logic [WCNT_W-1:0] LAST_BIT = WCNT_W'(WORD_BITS - 1);
  localparam logic [GAP_W-1:0]  LAST_GAP = GAP_W'(GAP_STEPS - 1);

  logic              serClkQ;
  logic [CNT_W-1:0]  bitCnt;
  logic [WCNT_W-1:0] hsCnt;
  logic [GAP_W-1:0]  gapCnt;
  hsState_e          state;
  logic              riseStep;
  logic              fallStep;

  assign riseStep = bitEn & ~serClkQ;
  assign fallStep = bitEn & serClkQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      serClkQ <= 1'b0;
      bitCnt  <= '1;
      hsCnt   <= '0;
      gapCnt  <= '0;
      state   <= HS_IDLE;
    end else if (!modeHs) begin
      if (bitEn) serClkQ <= ~serClkQ;
      if (riseStep) bitCnt <= bitCnt + 1'b1;
    end else begin
      unique case (state)
        HS_IDLE: begin
          if (bitEn && syncIn) begin
            state   <= HS_BURST;
            serClkQ <= 1'b1;
            hsCnt   <= '0;
          end
        end
        HS_BURST: begin
          if (bitEn) begin
            if (serClkQ) begin
              serClkQ <= 1'b0;
              if (hsCnt == LAST_BIT) begin
                state  <= HS_GAP;
                gapCnt <= '0;
              end
            end else begin
              serClkQ <= 1'b1;
              hsCnt   <= hsCnt + 1'b1;
            end
          end
        end
        HS_GAP: begin
          if (bitEn) begin
            if (gapCnt == LAST_GAP) state <= HS_IDLE;
            else gapCnt <= gapCnt + 1'b1;
          end
        end
        default: state <= HS_IDLE;
      endcase
    end
  end

  assign serClk          = serClkQ;
  assign syncOe          = ~modeHs;
  assign syncOut         = ~modeHs && (bitCnt < CNT_W'(WORD_BITS));
  assign strobe.sampleEn = fallStep;
  assign strobe.wordEnd  = fallStep &&
                           (modeHs ? (hsCnt == LAST_BIT)
                                   : (bitCnt[WCNT_W-1:0] == LAST_BIT));
  assign trackIdx        = modeHs ? '0 : bitCnt[CNT_W-1:WCNT_W];

  AST_HS_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    modeHs && state == HS_IDLE && !syncIn |=> !serClkQ); // R7

  AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    modeHs && state == HS_BURST && fallStep && hsCnt != LAST_BIT |=> state == HS_BURST); // R8

  AST_GAP_LOW: assert property (@(posedge clk) disable iff (!rstN)
    modeHs && state == HS_GAP |-> !serClkQ); // R9

  AST_SYNC_START: assert property (@(posedge clk) disable iff (!rstN)
    !modeHs && $rose(syncOut) |-> serClkQ && bitCnt == '0); // R3

endmodule

// File: rtl/gsr_datapath.sv
module gsr_datapath
  import gsr_pkg::*;
#(
  parameter int WORD_BITS = 16,
  parameter int TRK_W     = 3,
  parameter int TCNT_W    = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 modeHs,
  input  logic [TCNT_W-1:0]    trackCount,
  input  dpStrobe_t            strobe,
  input  logic [TRK_W-1:0]     trackIdx,
  input  logic                 serData,
  output logic [WORD_BITS-1:0] wordOut,
  output logic                 wordValid,
  output logic [TRK_W-1:0]     trackOut
);

  logic [WORD_BITS-2:0] shiftQ;
  logic                 keepWord;

  assign keepWord = modeHs || (TCNT_W'(trackIdx) < trackCount);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ    <= '0;
      wordOut   <= '0;
      wordValid <= 1'b0;
      trackOut  <= '0;
    end else begin
      wordValid <= 1'b0;
      if (strobe.sampleEn) shiftQ <= {shiftQ[WORD_BITS-3:0], serData};
      if (strobe.wordEnd && keepWord) begin
        wordOut   <= {shiftQ, serData};
        trackOut  <= trackIdx;
        wordValid <= 1'b1;
      end
    end
  end

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid); // R10

  AST_TRACK_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    !modeHs && wordValid |-> TCNT_W'(trackOut) < trackCount); // R6

  AST_HS_TRACK_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    modeHs && wordValid |-> trackOut == '0); // R8

endmodule

// File: rtl/gated_serial_rx.sv
module gated_serial_rx
  import gsr_pkg::*;
#(
  parameter int WORD_BITS  = 16,
  parameter int FRAME_BITS = 128,
  parameter int GAP_STEPS  = 4,
  localparam int TRACKS = FRAME_BITS / WORD_BITS,
  localparam int TRK_W  = $clog2(TRACKS),
  localparam int TCNT_W = $clog2(TRACKS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bitEn,
  input  logic                 modeHs,
  input  logic [TCNT_W-1:0]    trackCount,
  output logic                 serClk,
  input  logic                 serData,
  input  logic                 syncIn,
  output logic                 syncOut,
  output logic                 syncOe,
  output logic [WORD_BITS-1:0] wordOut,
  output logic                 wordValid,
  output logic [TRK_W-1:0]     trackOut
);

  dpStrobe_t        strobe;
  logic [TRK_W-1:0] trackIdx;

  gsr_ctrl #(
    .WORD_BITS (WORD_BITS),
    .FRAME_BITS(FRAME_BITS),
    .GAP_STEPS (GAP_STEPS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .bitEn   (bitEn),
    .modeHs  (modeHs),
    .syncIn  (syncIn),
    .serClk  (serClk),
    .syncOut (syncOut),
    .syncOe  (syncOe),
    .strobe  (strobe),
    .trackIdx(trackIdx)
  );

  gsr_datapath #(
    .WORD_BITS(WORD_BITS),
    .TRK_W    (TRK_W),
    .TCNT_W   (TCNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .modeHs    (modeHs),
    .trackCount(trackCount),
    .strobe    (strobe),
    .trackIdx  (trackIdx),
    .serData   (serData),
    .wordOut   (wordOut),
    .wordValid (wordValid),
    .trackOut  (trackOut)
  );

endmodule

// File: tb/gated_serial_rx_tb.sv
module gated_serial_rx_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitEn = 1'b0;
  logic        modeHs = 1'b0;
  logic [3:0]  trackCount = 4'd0;
  logic        serData = 1'b0;
  logic        syncIn = 1'b0;
  logic        serClk, syncOut, syncOe, wordValid;
  logic [15:0] wordOut;
  logic [2:0]  trackOut;

  int  errors = 0;
  int  checks = 0;
  bit  finished = 0;
  int  enPeriod = 1;
  int  divCnt = 0;

  // monitor / far-end model state
  bit  monOn = 0;
  bit  prevClk = 0, prevSync = 0;
  int  devFrame, bitPos, wordsInFrame, risesInFrame, syncRises, expTrack;
  int  hsBit, hsWordIdx, hsWordsRx, hsTarget, gapClk;
  bit  gapArmed;

  gated_serial_rx u_dut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .modeHs(modeHs),
    .trackCount(trackCount), .serClk(serClk), .serData(serData),
    .syncIn(syncIn), .syncOut(syncOut), .syncOe(syncOe),
    .wordOut(wordOut), .wordValid(wordValid), .trackOut(trackOut)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [15:0] expWord(int f, int t);
    return 16'(f * 11069 + t * 3895 + 33825);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // enable pulse generator
  always @(negedge clk) begin
    if (!rstN) begin
      divCnt = 0;
      bitEn <= 1'b0;
    end else begin
      bitEn <= (divCnt == enPeriod - 1);
      divCnt = (divCnt == enPeriod - 1) ? 0 : divCnt + 1;
    end
  end

  // far-end device model and output checker
  always @(negedge clk) begin
    bit rose, fell;
    logic [15:0] w;
    if (!rstN || !monOn) begin
      prevClk = serClk;
      prevSync = syncOut;
    end else begin
      rose = serClk && !prevClk;
      fell = !serClk && prevClk;
      gapClk++;
      if (wordValid) begin
        if (!modeHs) begin
          check(int'(trackOut) == expTrack && expTrack < int'(trackCount), "R5", "track index",
                trackOut, expTrack);
          check(wordOut == expWord(devFrame, int'(trackOut)), "R4", "continuous word",
                wordOut, expWord(devFrame, int'(trackOut)));
          expTrack++;
          wordsInFrame++;
        end else begin
          check(trackOut == 3'd0, "R8", "handshake track", trackOut, 0);
          check(wordOut == expWord(hsWordsRx, 5), "R4", "handshake word",
                wordOut, expWord(hsWordsRx, 5));
          hsWordsRx++;
        end
      end
      if (!modeHs) begin
        if (rose) begin
          if (syncOut && !prevSync) begin
            if (devFrame >= 0) begin
              check(wordsInFrame == int'(trackCount), "R6", "words per frame",
                    wordsInFrame, trackCount);
              check(risesInFrame == 128, "R2", "clocks per frame", risesInFrame, 128);
              check(syncRises == 16, "R3", "sync-high clocks", syncRises, 16);
            end
            devFrame++;
            bitPos = 0;
            wordsInFrame = 0;
            risesInFrame = 0;
            syncRises = 0;
            expTrack = 0;
          end else begin
            bitPos++;
          end
          risesInFrame++;
          if (syncOut) syncRises++;
          w = expWord(devFrame, bitPos / 16);
          serData = w[15 - (bitPos % 16)];
        end
      end else begin
        if (fell) gapClk = 0;
        if (rose) begin
          if (hsBit == 16) begin
            if (gapArmed)
              check(gapClk == 5 * enPeriod, "R9", "idle gap clocks", gapClk, 5 * enPeriod);
            gapArmed = 1;
            hsWordIdx++;
            hsBit = 0;
          end
          w = expWord(hsWordIdx, 5);
          serData = w[15 - hsBit];
          hsBit++;
          if (hsWordIdx == hsTarget - 1 && hsBit == 8) begin
            syncIn = 1'b0;
            gapArmed = 0;
          end
        end
      end
      prevClk = serClk;
      prevSync = syncOut;
    end
  end

  task automatic doReset(bit hs, int p, int tc);
    @(negedge clk);
    monOn = 0;
    rstN = 1'b0;
    modeHs = hs;
    enPeriod = p;
    trackCount = 4'(tc);
    syncIn = 1'b0;
    serData = 1'b0;
    repeat (3) @(negedge clk);
    check(!serClk && !syncOut && !wordValid, "R1", "reset outputs",
          {serClk, syncOut, wordValid}, 0);
    devFrame = -1; bitPos = 0; wordsInFrame = 0; risesInFrame = 0;
    syncRises = 0; expTrack = 0;
    hsBit = 16; hsWordIdx = -1; hsWordsRx = 0; gapClk = 0; gapArmed = 0;
    rstN = 1'b1;
    monOn = 1;
  endtask

  task automatic runCont(int p, int tc);
    doReset(0, p, tc);
    @(negedge clk);
    check(syncOe == 1'b1, "R3", "sync drive enable", syncOe, 1);
    while (devFrame < 3) @(negedge clk);
    monOn = 0;
  endtask

  task automatic runHs(int p, int n);
    doReset(1, p, 0);
    hsTarget = n;
    syncIn = 1'b1;
    while (hsWordsRx < n) @(negedge clk);
    check(syncOe == 1'b0, "R3", "sync released", syncOe, 0);
    repeat (60 * p + 20) @(negedge clk);
    check(hsWordsRx == n && !serClk, "R7", "no burst with sync low", hsWordsRx, n);
    check(hsWordIdx == n - 1, "R8", "bursts issued", hsWordIdx + 1, n);
    hsTarget = n + 1;
    syncIn = 1'b1;
    while (hsWordsRx < n + 1) @(negedge clk);
    repeat (60 * p + 20) @(negedge clk);
    check(hsWordsRx == n + 1 && !serClk, "R7", "resume then stop", hsWordsRx, n + 1);
    monOn = 0;
  endtask

  initial begin
    for (int p = 1; p <= 2; p++)
      for (int tc = 0; tc <= 8; tc++)
        runCont(p, tc);
    for (int p = 1; p <= 3; p++)
      for (int n = 1; n <= 3; n++)
        runHs(p, n);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule